// File: doc/BRIEF.md
# Bus-Cycle Fault Capture Register

This block holds sixteen sticky fault flags for a processor bus. Three active-low error lines, for protection, parity and external address, are looked at once per bus cycle. That moment is the clock edge at which the active-low busy line is first seen high after being low. The protection flag and the address flag each go to one of two positions. For protection the choice depends on whether the finished cycle was run by this CPU or by another master. For the address error it depends on whether the cycle was a memory or an I/O access. The busy line is watched during every bus cycle, whoever owns it, so errors in other masters' cycles are recorded as well.

Two system-fault inputs are asynchronous. Each passes through a synchronizer, and a rising edge sets its flags. Software clears flags with a strobe and a mask. A flag that is set stays set until it is cleared. A one-bit summary shows whether any flag is set.

Flags are numbered from the most significant end: fault bit n is carried on `faultReg[15-n]`. The clear mask uses the same vector positions as `faultReg`.

Top module: `bus_fault_capture`

## Requirements
- R1: The three error inputs are sampled only at a clock edge where `busBusyN` is high and was low at the previous edge. Errors that are asserted only while `busBusyN` stays low, or only while it stays high, set nothing.
- R2: A low `protErrN` at such an edge sets fault bit 0 when `cpuOwnsCycle` is 1, and sets fault bit 1 when `cpuOwnsCycle` is 0. This means cycles run by other masters are recorded too.
- R3: A low `parErrN` at such an edge sets fault bit 2, whatever the owner and the access kind.
- R4: A low `addrErrN` at such an edge sets fault bit 5 when `memCycle` is 1 (memory) and fault bit 8 when `memCycle` is 0 (I/O).
- R5: A rising edge on `sysFault0` sets fault bit 7. A pulse one clock long that is first sampled high at edge k shows on the output from edge k+2. Holding the input high sets the bit only once.
- R6: A rising edge on `sysFault1` sets both fault bit 13 and fault bit 15, with the same latency as R5.
- R7: A set bit stays set until a cycle with `clrStrobe`=1 whose `clrMask` has a 1 at the same vector position. Unmasked bits are kept.
- R8: If a bit is set and cleared in the same cycle, the set wins and the bit ends up 1.
- R9: Reset (`rstN`=0) forces `faultReg` to zero. `faultAny` is 1 exactly when `faultReg` is nonzero.
- R10: Fault bit n appears on `faultReg[15-n]`, so bit 0 is the most significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busBusyN | input | 1 | Bus busy, active low; its low-to-high change ends a cycle |
| cpuOwnsCycle | input | 1 | 1 when the current bus cycle is run by this CPU |
| memCycle | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| protErrN | input | 1 | Protection error, active low |
| parErrN | input | 1 | Parity error, active low |
| addrErrN | input | 1 | External address error, active low |
| sysFault0 | input | 1 | Asynchronous system fault, rising edge sets bit 7 |
| sysFault1 | input | 1 | Asynchronous system fault, rising edge sets bits 13 and 15 |
| clrStrobe | input | 1 | Apply clrMask this cycle |
| clrMask | input | 16 | Positions to clear, same layout as faultReg |
| faultReg | output | 16 | Sticky fault flags, fault bit n on position 15-n |
| faultAny | output | 1 | 1 when any flag is set |

## Verification
The hardest case to reach is a set and a clear of the same flag landing in one cycle. To get there, the bench raises `busBusyN` with a parity error pending and, on that same falling clock edge, asserts a clear with an all-ones mask. It also stretches the busy-low phase over several cycles while the errors are held low, and checks that nothing is recorded before the trailing edge. An exhaustive sweep covers every owner, access-kind and error combination.

// File: rtl/bus_fault_pkg.sv
package bus_fault_pkg;
  localparam int FAULT_W = 16;

  // Fault bit numbering counts from the most significant end.
  localparam int POS_PROT_OWN   = FAULT_W - 1 - 0;
  localparam int POS_PROT_OTHER = FAULT_W - 1 - 1;
  localparam int POS_PARITY     = FAULT_W - 1 - 2;
  localparam int POS_ADDR_MEM   = FAULT_W - 1 - 5;
  localparam int POS_SYS0       = FAULT_W - 1 - 7;
  localparam int POS_ADDR_IO    = FAULT_W - 1 - 8;
  localparam int POS_SYS1_A     = FAULT_W - 1 - 13;
  localparam int POS_SYS1_B     = FAULT_W - 1 - 15;

  localparam logic [FAULT_W-1:0] BUS_BITS =
    (FAULT_W'(1) << POS_PROT_OWN) | (FAULT_W'(1) << POS_PROT_OTHER) |
    (FAULT_W'(1) << POS_PARITY)   | (FAULT_W'(1) << POS_ADDR_MEM)   |
    (FAULT_W'(1) << POS_ADDR_IO);

  typedef struct packed {
    logic [FAULT_W-1:0] setMask;
    logic [FAULT_W-1:0] clrMask;
  } fault_cmd_t;
endpackage

// File: rtl/bus_fault_ctrl.sv
module bus_fault_ctrl
  import bus_fault_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busBusyN,
  input  logic               cpuOwnsCycle,
  input  logic               memCycle,
  input  logic               protErrN,
  input  logic               parErrN,
  input  logic               addrErrN,
  input  logic               sysFault0,
  input  logic               sysFault1,
  input  logic               clrStrobe,
  input  logic [FAULT_W-1:0] clrMask,
  output fault_cmd_t         cmd
);
  localparam int N_ASYNC = 2;

  logic               busyPrevQ;
  logic               trailEdge;
  logic [N_ASYNC-1:0] sysIn;
  logic [N_ASYNC-1:0] sysRise;
  logic [FAULT_W-1:0] setM;

  // Idle level of the busy line is high, so reset to high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyPrevQ <= 1'b1;
    else       busyPrevQ <= busBusyN;
  end

  assign trailEdge = busBusyN & ~busyPrevQ;
  assign sysIn     = {sysFault1, sysFault0};

  for (genvar g = 0; g < N_ASYNC; g++) begin : gSync
    logic [SYNC_STAGES:0] chainQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chainQ <= '0;
      else       chainQ <= {chainQ[SYNC_STAGES-1:0], sysIn[g]};
    end
    assign sysRise[g] = chainQ[SYNC_STAGES-1] & ~chainQ[SYNC_STAGES];
  end

  always_comb begin
    setM = '0;
    if (trailEdge) begin
      if (!protErrN) setM[cpuOwnsCycle ? POS_PROT_OWN : POS_PROT_OTHER] = 1'b1;
      if (!parErrN)  setM[POS_PARITY] = 1'b1;
      if (!addrErrN) setM[memCycle ? POS_ADDR_MEM : POS_ADDR_IO] = 1'b1;
    end
    if (sysRise[0]) setM[POS_SYS0] = 1'b1;
    if (sysRise[1]) begin
      setM[POS_SYS1_A] = 1'b1;
      setM[POS_SYS1_B] = 1'b1;
    end
  end

  assign cmd.setMask = setM;
  assign cmd.clrMask = clrStrobe ? clrMask : '0;

  AST_BUS_ON_TRAIL: assert property (@(posedge clk) disable iff (!rstN)
    (|(cmd.setMask & BUS_BITS)) |-> (busBusyN && !$past(busBusyN))); // R1
  AST_PROT_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    cmd.setMask[POS_PROT_OWN] |-> (cpuOwnsCycle && !protErrN)); // R2
  AST_PROT_OTHER: assert property (@(posedge clk) disable iff (!rstN)
    cmd.setMask[POS_PROT_OTHER] |-> (!cpuOwnsCycle && !protErrN)); // R2
  AST_ADDR_KIND: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.setMask[POS_ADDR_MEM] |-> memCycle) and
    (cmd.setMask[POS_ADDR_IO] |-> !memCycle)); // R4
endmodule

// File: rtl/bus_fault_dpath.sv
module bus_fault_dpath
  import bus_fault_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  fault_cmd_t         cmd,
  output logic [FAULT_W-1:0] faultQ,
  output logic               faultAny
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultQ <= '0;
    else       faultQ <= (faultQ & ~cmd.clrMask) | cmd.setMask;
  end

  assign faultAny = |faultQ;

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (|cmd.setMask) |=> ((($past(cmd.setMask)) & ~faultQ) == '0)); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (|faultQ) |=> (((($past(faultQ)) & ~($past(cmd.clrMask))) & ~faultQ) == '0)); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    (|faultQ) |-> ((faultQ & ~$past(faultQ) & ~$past(cmd.setMask)) == '0)); // R7
endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
  import bus_fault_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busBusyN,
  input  logic        cpuOwnsCycle,
  input  logic        memCycle,
  input  logic        protErrN,
  input  logic        parErrN,
  input  logic        addrErrN,
  input  logic        sysFault0,
  input  logic        sysFault1,
  input  logic        clrStrobe,
  input  logic [15:0] clrMask,
  output logic [15:0] faultReg,
  output logic        faultAny
);
  fault_cmd_t cmd;

  bus_fault_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busBusyN(busBusyN), .cpuOwnsCycle(cpuOwnsCycle),
    .memCycle(memCycle), .protErrN(protErrN), .parErrN(parErrN),
    .addrErrN(addrErrN), .sysFault0(sysFault0), .sysFault1(sysFault1),
    .clrStrobe(clrStrobe), .clrMask(clrMask), .cmd(cmd)
  );

  bus_fault_dpath u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .faultQ(faultReg), .faultAny(faultAny)
  );

  AST_ANY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    faultAny == (faultReg != '0)); // R9
endmodule

// File: tb/bus_fault_capture_tb.sv
module bus_fault_capture_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busBusyN = 1'b1, cpuOwnsCycle = 1'b1, memCycle = 1'b1;
  logic protErrN = 1'b1, parErrN = 1'b1, addrErrN = 1'b1;
  logic sysFault0 = 1'b0, sysFault1 = 1'b0;
  logic clrStrobe = 1'b0;
  logic [15:0] clrMask = '0;
  logic [15:0] faultReg;
  logic faultAny;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_fault_capture u_dut (
    .clk(clk), .rstN(rstN), .busBusyN(busBusyN), .cpuOwnsCycle(cpuOwnsCycle),
    .memCycle(memCycle), .protErrN(protErrN), .parErrN(parErrN),
    .addrErrN(addrErrN), .sysFault0(sysFault0), .sysFault1(sysFault1),
    .clrStrobe(clrStrobe), .clrMask(clrMask), .faultReg(faultReg),
    .faultAny(faultAny)
  );

  function automatic logic [15:0] pos(int n);
    return 16'h1 << (15 - n);
  endfunction

  function automatic logic [15:0] expBus(logic own, logic mem, logic p, logic r, logic a);
    logic [15:0] e = '0;
    if (!p) e |= own ? pos(0) : pos(1);
    if (!r) e |= pos(2);
    if (!a) e |= mem ? pos(5) : pos(8);
    return e;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s faultReg=%h expected=%h", tag, act, exp);
    end
    checks++;
    if (faultAny !== (exp != 0)) begin
      errors++;
      $display("FAIL %s/R9 faultAny=%b expected=%b", tag, faultAny, exp != 0);
    end
  endtask

  task automatic doClear(logic [15:0] m);
    @(negedge clk); clrStrobe = 1'b1; clrMask = m;
    @(negedge clk); clrStrobe = 1'b0; clrMask = '0;
  endtask

  task automatic busCycle(logic own, logic mem, logic p, logic r, logic a);
    @(negedge clk);
    busBusyN = 1'b0; cpuOwnsCycle = own; memCycle = mem;
    protErrN = p; parErrN = r; addrErrN = a;
    @(negedge clk); busBusyN = 1'b1;
    @(negedge clk);
    protErrN = 1'b1; parErrN = 1'b1; addrErrN = 1'b1;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", faultReg, 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R10: exhaustive owner/kind/error sweep
    for (int v = 0; v < 32; v++) begin
      logic own, mem, p, r, a;
      {own, mem, p, r, a} = 5'(v);
      doClear(16'hFFFF);
      busCycle(own, mem, p, r, a);
      check($sformatf("R2/R3/R4/R10 sweep %0d", v), faultReg, expBus(own, mem, p, r, a));
    end

    // R1: errors held across long busy-low phase, nothing before trailing edge
    doClear(16'hFFFF);
    @(negedge clk); busBusyN = 1'b0; parErrN = 1'b0; addrErrN = 1'b0; memCycle = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 busy-low no capture", faultReg, 16'h0);
    busBusyN = 1'b1;
    @(negedge clk);
    check("R1 capture at trailing edge", faultReg, pos(2) | pos(8));
    // R1: errors present while busy stays high set nothing
    doClear(16'hFFFF);
    @(negedge clk); protErrN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 idle errors ignored", faultReg, 16'h0);
    // R1: errors released at the trailing edge are not captured
    @(negedge clk); busBusyN = 1'b0;
    @(negedge clk); busBusyN = 1'b1; protErrN = 1'b1; parErrN = 1'b1; addrErrN = 1'b1;
    @(negedge clk);
    check("R1 errors gone at edge", faultReg, 16'h0);

    // R7: selective clear and stickiness
    memCycle = 1'b1;
    busCycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7 setup", faultReg, pos(2) | pos(5));
    repeat (3) @(negedge clk);
    check("R7 sticky", faultReg, pos(2) | pos(5));
    doClear(pos(2));
    check("R7 masked clear", faultReg, pos(5));

    // R8: set and clear in same cycle
    @(negedge clk); busBusyN = 1'b0; parErrN = 1'b0;
    @(negedge clk); busBusyN = 1'b1; clrStrobe = 1'b1; clrMask = 16'hFFFF;
    @(negedge clk); clrStrobe = 1'b0; clrMask = '0; parErrN = 1'b1;
    check("R8 set beats clear", faultReg, pos(2));
    doClear(16'hFFFF);

    // R5: one-clock pulse, exact latency
    @(negedge clk); sysFault0 = 1'b1;
    @(negedge clk); sysFault0 = 1'b0;
    @(negedge clk);
    check("R5 not yet", faultReg, 16'h0);
    @(negedge clk);
    check("R5 sys0 bit7", faultReg, pos(7));

    // R6: held high sets once
    doClear(16'hFFFF);
    @(negedge clk); sysFault1 = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 sys1 bits13/15", faultReg, pos(13) | pos(15));
    doClear(16'hFFFF);
    repeat (4) @(negedge clk);
    check("R6 level does not re-set", faultReg, 16'h0);
    @(negedge clk); sysFault1 = 1'b0; sysFault0 = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 held level sets once", faultReg, pos(7));
    doClear(16'hFFFF);
    repeat (3) @(negedge clk);
    check("R5 level does not re-set", faultReg, 16'h0);
    sysFault0 = 1'b0;

    // R9: reset wipes flags
    busCycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 before reset", faultReg, expBus(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    rstN = 1'b0;
    @(negedge clk);
    check("R9 after reset", faultReg, 16'h0);
    rstN = 1'b1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule